// File: doc/BRIEF.md
# Multi-lane partitioned sum engine

This block adds up a stream of signed integers, one word per handshake, and returns their total. A single running adder forces every addition to wait for the one before it. Here the adds are spread over `LANES` independent partial accumulators that exist side by side in hardware. Once the last word has been taken, a reduction phase walks the partial sums one per cycle and folds them into the final total. That total is then presented with a one-cycle `done` pulse.

The element count is supplied with the `start` pulse, so it can change from job to job at run time. Another input chosen at the same moment picks how words are spread across lanes. In interleaved order, word i goes to lane i mod `LANES`. In contiguous order, each lane takes a run of floor(N/`LANES`) consecutive words and the last lane also takes the remainder. Both orders yield the same exact total.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_LOAD` accepts words.
- `ST_REDUCE` folds one lane per cycle.
- `ST_FINISH` raises `done`.

The transitions are:
- idle→load on `start` with N>0.
- idle→reduce on `start` with N=0.
- load→reduce on acceptance of the N-th word.
- reduce→finish after the last lane has been folded.
- finish→idle with no `start`.
- finish→load or finish→reduce when `start` arrives in the done cycle.

Top module: `lane_sum_reducer`

## Requirements
- R1: `start` is honoured only in `ST_IDLE` or in the `done` cycle. There it clears every partial sum and the total, and it captures `count` and `order_sel`. A `start` while a job is loading or reducing has no effect on that job's result.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 exactly until N words have been taken. Words offered after that are not added.
- R3: With `order_sel`=0 (interleaved), `result` equals the exact signed sum of the N words, for any pattern of gaps in `in_valid`.
- R4: With `order_sel`=1 (contiguous), `result` equals the exact signed sum, including when N is not a multiple of `LANES` and when N < `LANES`.
- R5: N=0 returns 0 and never raises `in_ready`. N=1 returns the single word.
- R6: Partial sums, the total and `result` are `DATA_W`+clog2(`MAX_N`+1) bits wide. `MAX_N` words all at the most negative or the most positive value sum without overflow.
- R7: `done` is high for exactly one cycle per job. `result` changes only in that cycle and holds its value until the next `done`.
- R8: `done` is seen `LANES`+1 cycles after the cycle in which the last word is taken, or after the `start` cycle when N=0.
- R9: A `start` in the `done` cycle launches the next job at once with correct results. A `done` cycle without `start` leaves `in_ready` low in the following cycle.
- R10: In interleaved order the first word goes to lane 0, and each later word goes to the lane after the previous one, wrapping modulo `LANES`.
- R11: In contiguous order the lane index never decreases within a job. Lanes below the last take floor(N/`LANES`) words each (`LANES` is a power of two).
- R12: After reset, `done`=0, `in_ready`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a job (honoured in idle or the done cycle) |
| count | input | CNT_W | Number of words in the job, sampled with start |
| order_sel | input | 1 | Lane assignment: 0 interleaved, 1 contiguous |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | DATA_W | Signed input word |
| done | output | 1 | One-cycle pulse when result is new |
| result | output | ACC_W | Signed total of the job |

## Verification
Two functions share one cycle: delivering one job's total with `done` and accepting the `start` of the next job. The bench provokes this by raising `start` in exactly the cycle where it sees `done`. It chains jobs this way, including an empty job. Each chained total must still be exact and must arrive with the fixed latency, which shows that the clear of the new job did not corrupt the delivery of the old one.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_REDUCE = 2'd2,
        ST_FINISH = 2'd3
    } lsr_state_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_CONTIG     = 1'b1
    } lsr_order_e;

endpackage

// File: rtl/lsr_lane_pick.sv
module lsr_lane_pick
    import lsr_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 7,
    parameter int LW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] count_in,
    input  logic             order_in,
    input  logic             advance,
    output logic [LW-1:0]    lane_sel
);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    lsr_order_e       order_q;
    logic [LW-1:0]    lane_q;
    logic [CNT_W-1:0] blk_q;
    logic [CNT_W-1:0] bsize_q;
    logic [CNT_W-1:0] bsize_in;

    // words per lane in contiguous order: floor(N / LANES)
    assign bsize_in = count_in >> LW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            order_q <= ORD_INTERLEAVE;
            lane_q  <= '0;
            blk_q   <= '0;
            bsize_q <= '0;
        end else if (clear) begin
            order_q <= lsr_order_e'(order_in);
            bsize_q <= bsize_in;
            blk_q   <= '0;
            // fewer words than lanes: every word lands in the last lane
            if (order_in == ORD_CONTIG && bsize_in == '0)
                lane_q <= LAST_LANE;
            else
                lane_q <= '0;
        end else if (advance) begin
            unique case (order_q)
                ORD_INTERLEAVE: lane_q <= lane_q + 1'b1;
                ORD_CONTIG: begin
                    if (lane_q != LAST_LANE && blk_q == bsize_q - 1'b1) begin
                        lane_q <= lane_q + 1'b1;
                        blk_q  <= '0;
                    end else begin
                        blk_q  <= blk_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign lane_sel = lane_q;

endmodule

// File: rtl/lsr_lane_bank.sv
module lsr_lane_bank #(
    parameter int LANES  = 4,
    parameter int LW     = 2,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         add,
    input  logic [LW-1:0]                lane_sel,
    input  logic [DATA_W-1:0]            data,
    output logic [LANES-1:0][ACC_W-1:0]  partials
);
    logic [ACC_W-1:0] data_ext;

    assign data_ext = {{(ACC_W-DATA_W){data[DATA_W-1]}}, data};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ACC_W-1:0] part_q;
        logic             hit;

        assign hit = add && (lane_sel == LW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                part_q <= '0;
            else if (clear)
                part_q <= '0;
            else if (hit)
                part_q <= part_q + data_ext;
        end

        assign partials[g] = part_q;
    end

endmodule

// File: rtl/lane_sum_reducer.sv
module lane_sum_reducer
    import lsr_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int LANES  = 4,
    parameter  int MAX_N  = 64,
    localparam int CNT_W  = $clog2(MAX_N + 1),
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int ACC_W  = DATA_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic              order_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              done,
    output logic [ACC_W-1:0]  result
);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    lsr_state_e state_q, state_d;

    logic [CNT_W-1:0]             count_q;
    logic [CNT_W-1:0]             elem_q;
    logic [LW-1:0]                ridx_q;
    logic [ACC_W-1:0]             total_q;
    logic [ACC_W-1:0]             result_q;
    logic [LW-1:0]                lane_sel;
    logic [LANES-1:0][ACC_W-1:0]  partials;
    logic                         launch;
    logic                         acc_fire;
    logic                         last_elem;

    assign launch    = start && (state_q == ST_IDLE || state_q == ST_FINISH);
    assign acc_fire  = in_valid && in_ready;
    assign last_elem = (elem_q == count_q - 1'b1);

    lsr_lane_pick #(.LANES(LANES), .CNT_W(CNT_W), .LW(LW)) pick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .count_in (count),
        .order_in (order_sel),
        .advance  (acc_fire),
        .lane_sel (lane_sel)
    );

    lsr_lane_bank #(.LANES(LANES), .LW(LW), .DATA_W(DATA_W), .ACC_W(ACC_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (launch),
        .add      (acc_fire),
        .lane_sel (lane_sel),
        .data     (in_data),
        .partials (partials)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (start) state_d = (count == '0) ? ST_REDUCE : ST_LOAD;
            ST_LOAD:
                if (acc_fire && last_elem) state_d = ST_REDUCE;
            ST_REDUCE:
                if (ridx_q == LAST_LANE) state_d = ST_FINISH;
            ST_FINISH:
                if (start) state_d = (count == '0) ? ST_REDUCE : ST_LOAD;
                else       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // job counters and reduction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            elem_q   <= '0;
            ridx_q   <= '0;
            total_q  <= '0;
            result_q <= '0;
        end else begin
            if (launch) begin
                count_q <= count;
                elem_q  <= '0;
                ridx_q  <= '0;
                total_q <= '0;
            end else begin
                if (acc_fire)
                    elem_q <= elem_q + 1'b1;
                if (state_q == ST_REDUCE) begin
                    total_q <= total_q + partials[ridx_q];
                    ridx_q  <= ridx_q + 1'b1;
                    if (ridx_q == LAST_LANE)
                        result_q <= total_q + partials[ridx_q];
                end
            end
        end
    end

    // outputs
    always_comb begin
        in_ready = (state_q == ST_LOAD);
        done     = (state_q == ST_FINISH);
        result   = result_q;
    end

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
    parameter int LW    = 2,
    parameter int CNT_W = 7,
    parameter int ACC_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic             order_sel,
    input logic             done,
    input logic             in_ready,
    input logic [ACC_W-1:0] result,
    input logic             launch,
    input logic             acc_fire,
    input logic [LW-1:0]    lane_sel
);
    logic [LW-1:0] last_q;
    logic          seen_q;
    logic          ord_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
            ord_q  <= 1'b0;
        end else if (launch) begin
            seen_q <= 1'b0;
            ord_q  <= order_sel;
        end else if (acc_fire) begin
            seen_q <= 1'b1;
            last_q <= lane_sel;
        end
    end

    assert_first_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !seen_q && !ord_q) |-> (lane_sel == '0));

    assert_interleave_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && seen_q && !ord_q) |-> (lane_sel == LW'(last_q + 1'b1)));

    assert_contig_monotone_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && seen_q && ord_q) |-> (lane_sel >= last_q));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !in_ready);

    assert_empty_job_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && count == '0) |=> !in_ready);

endmodule

bind lane_sum_reducer lsr_checker #(.LW(LW), .CNT_W(CNT_W), .ACC_W(ACC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count     (count),
    .order_sel (order_sel),
    .done      (done),
    .in_ready  (in_ready),
    .result    (result),
    .launch    (launch),
    .acc_fire  (acc_fire),
    .lane_sel  (lane_sel)
);

// File: tb/lane_sum_reducer_tb.sv
module lane_sum_reducer_tb_top;
    localparam int DW   = 8;
    localparam int L    = 4;
    localparam int MAXN = 64;
    localparam int CW   = $clog2(MAXN + 1);
    localparam int AW   = DW + CW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [CW-1:0] count;
    logic          order_sel;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          done;
    logic [AW-1:0] result;

    int  errs   = 0;
    int  checks = 0;
    longint last_exp = 0;

    always #5 clk = ~clk;

    lane_sum_reducer #(.DATA_W(DW), .LANES(L), .MAX_N(MAXN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .order_sel(order_sel), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int elem(input int kind, input int seed, input int k);
        if (kind == 1) return -128;
        if (kind == 2) return 127;
        return ((k * 37 + seed * 11 + 5) % 256) - 128;
    endfunction

    function automatic longint sres(input logic [AW-1:0] v);
        return longint'($signed(v));
    endfunction

    // chained=1: called at the negedge where done is high, start goes out now (R9)
    task automatic do_job(input int n, input bit mode, input int gap, input int kind,
                          input int seed, input bit chained, input bit poke, input string req);
        longint exp = 0;
        int     k = 0;
        int     lat = 0;
        int     guard = 0;
        bit     extra_ready = 0;
        if (!chained) begin
            @(negedge clk);
            chk(done == 1'b0, "R7", done, 0);
            chk(sres(result) == last_exp, "R7", sres(result), last_exp);
        end
        for (int i = 0; i < n; i++) exp += elem(kind, seed, i);
        start     = 1'b1;
        count     = CW'(n);
        order_sel = mode;
        in_valid  = 1'b0;
        lat       = 0;
        @(negedge clk);
        start = 1'b0;
        while (guard < 2000) begin
            lat++;
            if (done) break;
            if (k < n) begin
                in_valid = (gap == 0) || ((guard % 3) != 2);
                in_data  = DW'(elem(kind, seed, k));
                if (in_valid && in_ready) begin
                    k++;
                    if (k == n) lat = 0;
                end
            end else begin
                if (in_ready) extra_ready = 1'b1;
                in_valid = 1'b1;
                in_data  = DW'(77);
            end
            // R1: start pulses while busy, with a zero count, must be ignored
            start = poke && (k == 2);
            if (poke) count = '0;
            guard++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        start    = 1'b0;
        chk(done == 1'b1, "R7", done, 1);
        chk(sres(result) == exp, req, sres(result), exp);
        chk(lat == L + 1, "R8", lat, L + 1);
        chk(!extra_ready && k == n, "R2", k, n);
        last_exp = exp;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; count = '0; order_sel = 1'b0;
        in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R12", done, 0);
        chk(in_ready == 1'b0, "R12", in_ready, 0);
        chk(sres(result) == 0, "R12", sres(result), 0);
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < 2; g++) begin
                for (int n = 0; n <= 20; n++) begin
                    string tag;
                    if (n <= 1)      tag = "R5";
                    else if (m == 0) tag = "R3 R10";
                    else             tag = "R4 R11";
                    do_job(n, m[0], g, 0, n + m * 3 + g, 1'b0, 1'b0, tag);
                end
            end
        end

        // R6: full-scale inputs
        do_job(MAXN, 1'b0, 0, 1, 0, 1'b0, 1'b0, "R6");
        do_job(MAXN, 1'b1, 1, 2, 0, 1'b0, 1'b0, "R6");
        do_job(MAXN - 1, 1'b1, 0, 1, 0, 1'b0, 1'b0, "R6");

        // R9: back-to-back jobs launched in the done cycle
        do_job(7, 1'b0, 0, 0, 9, 1'b0, 1'b0, "R3");
        do_job(5, 1'b1, 1, 0, 4, 1'b1, 1'b0, "R9");
        do_job(0, 1'b0, 0, 0, 0, 1'b1, 1'b0, "R9");
        do_job(6, 1'b1, 0, 0, 8, 1'b1, 1'b0, "R9");

        // R1: start while busy is ignored; next job starts from clean partials
        do_job(10, 1'b1, 1, 0, 2, 1'b0, 1'b1, "R1");
        do_job(11, 1'b0, 0, 0, 3, 1'b0, 1'b1, "R1");

        @(negedge clk);
        chk(done == 1'b0, "R7", done, 0);
        chk(in_ready == 1'b0, "R9", in_ready, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule